// File: doc/BRIEF.md
# Clock Rate Calibrator

This block is one stage of the divider chain that turns an oscillator-rate enable into seconds. It trims the clock rate digitally, not by tuning the crystal. A fixed prescaler divides the enable into sub-second stages, and a stage counter divides those into seconds. A signed calibration setting selects which seconds inside a repeating cycle of minutes are made slightly shorter or slightly longer than nominal. A positive setting makes the clock run fast and a negative one makes it run slow. The correction steps are uneven: a shortened second loses one whole prescaler period, while a lengthened second gains half of one.

The calibration setting is captured only at the origin of each correction cycle, so a change made in the middle of a cycle applies from the next cycle. The block also has a frequency-test path. A divider that ignores calibration toggles a flag at the test rate, and that flag appears on the test output only while frequency test is enabled, the oscillator is running and the seconds register is being read. When the stop input is high, every counter holds and neither a tick nor a test toggle is produced.

Top module: `clock_calibrator`

## Requirements
- R1: During and straight after reset, `sec_tick` and `ft_out` are low, and every counter starts at zero.
- R2: A second that is not corrected lasts exactly OSC_HZ enabled cycles, counted as rising edges with `osc_en`=1 and `stop`=0, from one `sec_tick` pulse to the next. The first second is counted from reset release.
- R3: With `cal_pos`=1 and magnitude N>0, second 0 of each minute m < 2N of the cycle lasts OSC_HZ-PRE_DIV enabled cycles. Minutes are indexed 0 to MIN_PER_CYCLE-1 and seconds 0 to SEC_PER_MIN-1.
- R4: With `cal_pos`=0 and magnitude N>0, second 0 of each minute m < 2N lasts OSC_HZ+PRE_DIV/2 enabled cycles.
- R5: A magnitude of 0 leaves every second at OSC_HZ enabled cycles, whatever the value of `cal_pos`.
- R6: `cal_mag` and `cal_pos` are captured at the first enabled cycle at the origin of a correction cycle. A change made inside a cycle has no effect on that cycle's second lengths and governs the next cycle.
- R7: A rising edge with `osc_en`=0 advances nothing, so the lengths in R2 to R5 hold for any gap pattern.
- R8: While `stop`=1, all counters hold, `sec_tick` stays low and `ft_out` is low. Counting resumes from the held state when `stop` falls.
- R9: `ft_out` equals an internal flag that toggles every OSC_HZ/(2*TEST_HZ) enabled cycles, starting from 0 at reset. This holds while `ft_en`=1, `rd_sec`=1 and `stop`=0. Otherwise `ft_out` is 0.
- R10: The calibration setting has no effect on the timing of the test flag.
- R11: `sec_tick` is a single-cycle pulse, registered one clock after the enabled edge that ends the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_en | input | 1 | One pulse per oscillator period |
| cal_mag | input | CAL_W | Calibration magnitude, 0 to 2^CAL_W-1 |
| cal_pos | input | 1 | Calibration sign: 1 = speed up, 0 = slow down |
| ft_en | input | 1 | Frequency-test enable |
| stop | input | 1 | Oscillator stop: holds all counters |
| rd_sec | input | 1 | High while the seconds register is read |
| sec_tick | output | 1 | Corrected one-second pulse |
| ft_out | output | 1 | Frequency-test signal |

## Verification
The bench builds the block with OSC_HZ=64, PRE_DIV=8, SEC_PER_MIN=4, MIN_PER_CYCLE=8, CAL_W=2 and TEST_HZ=4. With these values a whole correction cycle is 32 seconds of about 64 clocks each. Every second of a full cycle can therefore be timed for every magnitude and both signs. The widest schedule, with minutes 0 to 5 corrected and 6 to 7 clean, is fully covered. The small test half-period of 8 enabled cycles allows the test flag to be followed edge by edge under a gapped enable. The same small values keep a mid-cycle change of setting, and the cycle that follows it, to about 4,000 clocks.

// File: rtl/calib_pkg.sv
// Package: shared types of the clock-rate calibrator.
// Assumes nothing beyond IEEE 1800-2017.
package calib_pkg;
    // Kind of correction applied to the second currently being counted
    typedef enum logic [1:0] {
        CORR_NONE  = 2'd0,
        CORR_SHORT = 2'd1,
        CORR_LONG  = 2'd2
    } corr_e;
endpackage

// File: rtl/calib_divider.sv
// Module: prescaler plus stage counter that forms one second from the
// oscillator enable. A SHORT second drops its final stage, which removes
// PRE_DIV cycles. A LONG second stretches its final prescaler period by
// PRE_DIV/2. Assumes OSC_HZ is a multiple of PRE_DIV with at least two
// stages, and that PRE_DIV is even.
module calib_divider
    import calib_pkg::*;
#(
    parameter int OSC_HZ  = 32768,
    parameter int PRE_DIV = 256
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  corr_e corr,
    output logic  sec_end,
    output logic  at_zero
);
    localparam int STAGES    = OSC_HZ / PRE_DIV;
    localparam int LONG_TERM = PRE_DIV + PRE_DIV / 2 - 1;
    localparam int PW        = $clog2(LONG_TERM + 1);
    localparam int SW        = $clog2(STAGES);

    logic [PW-1:0] presc_q;
    logic [SW-1:0] stage_q;
    logic [SW-1:0] last_stage;
    logic [PW-1:0] term;
    logic          presc_wrap;

    // Pick the terminal counts for the second in progress
    always_comb begin
        last_stage = (corr == CORR_SHORT) ? SW'(STAGES - 2) : SW'(STAGES - 1);
        term       = (corr == CORR_LONG && stage_q == last_stage) ? PW'(LONG_TERM)
                                                                  : PW'(PRE_DIV - 1);
        presc_wrap = (presc_q == term);
        sec_end    = en && presc_wrap && (stage_q == last_stage);
        at_zero    = (presc_q == '0) && (stage_q == '0);
    end

    // Advance prescaler and stage counter on each enabled cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
            stage_q <= '0;
        end else if (en) begin
            if (presc_wrap) begin
                presc_q <= '0;
                stage_q <= (stage_q == last_stage) ? '0 : stage_q + SW'(1);
            end else begin
                presc_q <= presc_q + PW'(1);
            end
        end
    end
endmodule

// File: rtl/calib_schedule.sv
// Module: second and minute counters of the correction cycle. Holds the
// calibration setting captured at the cycle origin and decides whether the
// current second is shortened, lengthened or left alone. Only second 0 of a
// minute is ever corrected. Assumes MIN_PER_CYCLE > 2*(2^CAL_W-1).
module calib_schedule
    import calib_pkg::*;
#(
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64,
    parameter int CAL_W         = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sec_end,
    input  logic             at_zero,
    input  logic [CAL_W-1:0] cal_mag,
    input  logic             cal_pos,
    output corr_e            corr
);
    localparam int SECW = $clog2(SEC_PER_MIN);
    localparam int MINW = $clog2(MIN_PER_CYCLE);

    logic [SECW-1:0]  sec_q;
    logic [MINW-1:0]  min_q;
    logic [CAL_W-1:0] mag_q;
    logic             pos_q;
    logic             capture;

    // Capture point and correction decision for the current second
    always_comb begin
        capture = en && at_zero && (sec_q == '0) && (min_q == '0);
        corr    = CORR_NONE;
        if (sec_q == '0 && mag_q != '0 && int'(min_q) < 2 * int'(mag_q))
            corr = pos_q ? CORR_SHORT : CORR_LONG;
    end

    // Count seconds within the minute and minutes within the cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            min_q <= '0;
        end else if (sec_end) begin
            if (sec_q == SECW'(SEC_PER_MIN - 1)) begin
                sec_q <= '0;
                min_q <= (min_q == MINW'(MIN_PER_CYCLE - 1)) ? '0 : min_q + MINW'(1);
            end else begin
                sec_q <= sec_q + SECW'(1);
            end
        end
    end

    // Latch the calibration setting at the cycle origin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mag_q <= '0;
            pos_q <= 1'b0;
        end else if (capture) begin
            mag_q <= cal_mag;
            pos_q <= cal_pos;
        end
    end
endmodule

// File: rtl/calib_testdiv.sv
// Module: divider for the frequency-test flag. It runs from the raw enable
// and never sees calibration. Assumes OSC_HZ is a multiple of 2*TEST_HZ.
module calib_testdiv #(
    parameter int OSC_HZ  = 32768,
    parameter int TEST_HZ = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic show,
    output logic ft_out
);
    localparam int HALF = OSC_HZ / (2 * TEST_HZ);
    localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [HW-1:0] cnt_q;
    logic          tog_q;

    // Toggle the flag every HALF enabled cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tog_q <= 1'b0;
        end else if (en) begin
            if (cnt_q == HW'(HALF - 1)) begin
                cnt_q <= '0;
                tog_q <= ~tog_q;
            end else begin
                cnt_q <= cnt_q + HW'(1);
            end
        end
    end

    // Drive the flag out only while the test read is active
    always_comb ft_out = tog_q && show;
endmodule

// File: rtl/clock_calibrator.sv
// Module: top of the clock-rate calibrator. It joins the second divider,
// the correction schedule and the test divider, and registers the
// one-second pulse. Assumes osc_en is synchronous to clk.
module clock_calibrator
    import calib_pkg::*;
#(
    parameter int OSC_HZ        = 32768,
    parameter int PRE_DIV       = 256,
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64,
    parameter int CAL_W         = 5,
    parameter int TEST_HZ       = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_en,
    input  logic [CAL_W-1:0] cal_mag,
    input  logic             cal_pos,
    input  logic             ft_en,
    input  logic             stop,
    input  logic             rd_sec,
    output logic             sec_tick,
    output logic             ft_out
);
    logic  run;
    logic  sec_end;
    logic  at_zero;
    logic  show;
    corr_e corr;

    // Gate the enable with the stop input and qualify the test read
    always_comb begin
        run  = osc_en && !stop;
        show = ft_en && rd_sec && !stop;
    end

    calib_divider #(.OSC_HZ(OSC_HZ), .PRE_DIV(PRE_DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .en(run), .corr(corr),
        .sec_end(sec_end), .at_zero(at_zero)
    );

    calib_schedule #(.SEC_PER_MIN(SEC_PER_MIN), .MIN_PER_CYCLE(MIN_PER_CYCLE),
                     .CAL_W(CAL_W)) u_sched (
        .clk(clk), .rst_n(rst_n), .en(run), .sec_end(sec_end), .at_zero(at_zero),
        .cal_mag(cal_mag), .cal_pos(cal_pos), .corr(corr)
    );

    calib_testdiv #(.OSC_HZ(OSC_HZ), .TEST_HZ(TEST_HZ)) u_test (
        .clk(clk), .rst_n(rst_n), .en(run), .show(show), .ft_out(ft_out)
    );

    // Register the end-of-second pulse
    always_ff @(posedge clk) begin
        if (!rst_n) sec_tick <= 1'b0;
        else        sec_tick <= sec_end;
    end
endmodule

// File: rtl/calib_checker.sv
// Module: port-level properties of the clock-rate calibrator, bound to the top.
module calib_checker (
    input logic clk,
    input logic rst_n,
    input logic osc_en,
    input logic ft_en,
    input logic stop,
    input logic rd_sec,
    input logic sec_tick,
    input logic ft_out
);
    AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick); // R11

    AST_NO_TICK_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stop) || !$past(osc_en)) |-> !sec_tick); // R8

    AST_TEST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (stop || !ft_en || !rd_sec) |-> !ft_out); // R9

    AST_TEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ft_en && rd_sec && !stop && $past(ft_en && rd_sec && !stop && !osc_en))
        |-> $stable(ft_out)); // R7
endmodule

bind clock_calibrator calib_checker u_chk (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .ft_en(ft_en), .stop(stop),
    .rd_sec(rd_sec), .sec_tick(sec_tick), .ft_out(ft_out)
);

// File: tb/sim_clock_calibrator.sv
module sim_clock_calibrator;
    localparam int OSC  = 64;
    localparam int PRE  = 8;
    localparam int SPM  = 4;
    localparam int MPC  = 8;
    localparam int CW   = 2;
    localparam int THZ  = 4;
    localparam int HALF = OSC / (2 * THZ);
    localparam int SPC  = SPM * MPC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          osc_en = 1'b0;
    logic [CW-1:0] cal_mag = '0;
    logic          cal_pos = 1'b0;
    logic          ft_en = 1'b0;
    logic          stop = 1'b0;
    logic          rd_sec = 1'b0;
    logic          sec_tick;
    logic          ft_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    clock_calibrator #(.OSC_HZ(OSC), .PRE_DIV(PRE), .SEC_PER_MIN(SPM),
                       .MIN_PER_CYCLE(MPC), .CAL_W(CW), .TEST_HZ(THZ)) u0 (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .cal_mag(cal_mag), .cal_pos(cal_pos),
        .ft_en(ft_en), .stop(stop), .rd_sec(rd_sec), .sec_tick(sec_tick), .ft_out(ft_out)
    );

    function automatic int exp_len(int idx, int mag, bit pos);
        int m = (idx % SPC) / SPM;
        int s = idx % SPM;
        if (s == 0 && mag != 0 && m < 2 * mag) return pos ? OSC - PRE : OSC + PRE / 2;
        return OSC;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; osc_en = 1'b0; stop = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Count enabled edges up to the next tick. The stop window and the gap pattern are given as arguments.
    task automatic measure(input int stop_at, input int stop_len, input bit gap,
                           output int n, output bit bad);
        bit en_s;
        bit st_s;
        n = 0; bad = 0;
        for (int i = 0; i < 100000; i++) begin
            st_s   = (i >= stop_at && i < stop_at + stop_len);
            en_s   = gap ? ((i % 3) != 2) : 1'b1;
            osc_en = en_s;
            stop   = st_s;
            @(posedge clk);
            @(negedge clk);
            if (en_s && !st_s) n++;
            if (st_s && (sec_tick || ft_out)) bad = 1;
            if (sec_tick) break;
        end
        stop = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int  n;
        bit  bad;
        int  k;
        // R1: reset state
        ft_en = 1'b1; rd_sec = 1'b1;
        do_reset();
        check("R1 tick after reset", int'(sec_tick), 0);
        check("R1 test flag after reset", int'(ft_out), 0);
        ft_en = 1'b0; rd_sec = 1'b0;

        // R2 R3 R4 R5 R11: every second of a full cycle, all settings
        for (int p = 0; p < 2; p++) begin
            for (int mg = 0; mg < (1 << CW); mg++) begin
                cal_mag = CW'(mg); cal_pos = p[0];
                do_reset();
                for (int idx = 0; idx < SPC; idx++) begin
                    measure(-1, 0, 1'b0, n, bad);
                    check(mg == 0 ? "R5 zero magnitude" :
                          (exp_len(idx, mg, p[0]) == OSC ? "R2 R11 plain second" :
                           (p != 0 ? "R3 shortened second" : "R4 lengthened second")),
                          n, exp_len(idx, mg, p[0]));
                end
            end
        end

        // R6: change mid-cycle, effective from the next cycle
        cal_mag = 2'd1; cal_pos = 1'b1;
        do_reset();
        for (int idx = 0; idx < 2 * SPC; idx++) begin
            if (idx == 3) begin cal_mag = 2'd3; cal_pos = 1'b0; end
            measure(-1, 0, 1'b0, n, bad);
            check("R6 capture at cycle origin", n,
                  idx < SPC ? exp_len(idx, 1, 1'b1) : exp_len(idx, 3, 1'b0));
        end

        // R7: gapped enable over a full cycle
        cal_mag = 2'd2; cal_pos = 1'b1;
        do_reset();
        for (int idx = 0; idx < SPC; idx++) begin
            measure(-1, 0, 1'b1, n, bad);
            check("R7 gapped enable", n, exp_len(idx, 2, 1'b1));
        end

        // R8: stop holds counters, no tick and no test output while held
        cal_mag = 2'd1; cal_pos = 1'b0;
        ft_en = 1'b1; rd_sec = 1'b1;
        do_reset();
        measure(20, 300, 1'b0, n, bad);
        check("R8 length across stop", n, OSC + PRE / 2);
        check("R8 quiet while stopped", int'(bad), 0);
        measure(5, 40, 1'b1, n, bad);
        check("R8 second after stop", n, OSC);
        check("R8 quiet while stopped gapped", int'(bad), 0);

        // R9 R10: test flag follows enabled edges, with and without calibration
        for (int run = 0; run < 2; run++) begin
            cal_mag = run != 0 ? 2'd3 : 2'd0; cal_pos = 1'b1;
            ft_en = 1'b1; rd_sec = 1'b1;
            do_reset();
            k = 0; bad = 0;
            for (int i = 0; i < 6 * HALF * 2; i++) begin
                osc_en = (i % 3) != 1;
                @(posedge clk);
                @(negedge clk);
                if (osc_en) k++;
                if (int'(ft_out) != ((k / HALF) % 2)) bad = 1;
            end
            check(run != 0 ? "R10 test flag under calibration" : "R9 test flag timing",
                  int'(bad), 0);
            rd_sec = 1'b0;
            @(negedge clk);
            check("R9 no read no output", int'(ft_out), 0);
            rd_sec = 1'b1; ft_en = 1'b0;
            @(negedge clk);
            check("R9 test disabled no output", int'(ft_out), 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule